// File: doc/BRIEF.md
# Self-Routing Circuit-Switched Delta Network

This block connects N requesters to N memory ports through log2(N) stages of two-by-two switch elements, N/2 elements per stage, with a perfect-shuffle wiring in front of every stage. The default is eight ports and three stages. A requester drives a destination port number and raises its request line. Each element looks at one bit of that number and sends the request either straight or crossed. No central controller is involved. When two requests want the same element output, the element settles the contest itself and the loser is simply left waiting.

An element output, once won, stays owned for as long as the requester keeps its request high. A block burst of data words can therefore stream through the established path, one word per cycle, with no setup cost after the first word. The requester learns that its path is complete from its acknowledge line. This line rises only after the last stage has reached the destination port and that port reports itself idle. Dropping the request frees every element on the path at the same clock edge. Switch cost grows as N log2 N, where a full crossbar costs N squared.

Top module: `delta_net`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ack_o`, `mem_req_o` and `mem_data_o` are all zero.
- R2: A lone request from any source s to any destination d is routed without a central controller. `mem_req_o[d]` and `ack_o[s]` are low after 3 clock edges and high after 4 edges (stages plus one output register), counted from the edge that first samples the request. No other memory port or acknowledge is active.
- R3: Stage i steers on destination bit (log2N-1-i), most significant bit first. Bit value 0 selects element output 0 and 1 selects output 1. As a result, every uniform shift permutation (source s to destination (s+k) mod N, all sources at once) connects every requester concurrently, with each word landing at its own destination.
- R4: When two requests need the same element output, only one is granted. The loser gets no acknowledge, and none of its data reaches any memory port. It keeps requesting and is granted once the winner releases.
- R5: Requester j enters stage 0 on line rotl(j), a one-bit left rotation of the index, and element k takes line 2k as input 0 and line 2k+1 as input 1. So requesters 0 and 4 share stage-0 element 0, as inputs 0 and 1. The first collision after reset goes to input 0. Each element's priority flips after every collision it resolves, so the next collision there goes to input 1.
- R6: The acknowledge is given only while `mem_idle_i` of the destination is high. While the port is busy the path is still held and `mem_req_o[d]` is raised. `ack_o` rises one edge after the port becomes idle.
- R7: While a path is held, the word on `data_i[s]` appears on `mem_data_o[d]` one clock edge later, every cycle.
- R8: Dropping `req_i[s]` clears `ack_o[s]` and `mem_req_o[d]` at the next edge and frees every element of the path at that same edge. A waiting request through a freed element is granted on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N | Request line per requester |
| dest_i | input | N x log2N | Destination port number per requester |
| data_i | input | N x DW | Data word per requester |
| ack_o | output | N | Path-complete acknowledge per requester (registered) |
| mem_idle_i | input | N | Memory port is free to accept a connection |
| mem_req_o | output | N | Request arriving at each memory port (registered) |
| mem_data_o | output | N x DW | Data word arriving at each memory port (registered) |

## Verification
The properties assume that a requester holds its destination steady for as long as its request is high, and that inputs change away from the clock edge. The stimulus meets both conditions: it sets the destination and the request together at a falling edge, leaves them unchanged until the request is dropped, and changes only the data word during a hold. The sweeps cover every source-destination pair alone, every uniform shift with all eight requesters active, a forced collision at one stage-0 element resolved twice so that both priority states are exercised, and a held path waiting on a busy memory port.

// File: rtl/delta_pkg.sv
package delta_pkg;
  // one-bit left rotation of a line index: the perfect shuffle
  function automatic int rotl(input int j, input int bits);
    return ((j << 1) | (j >> (bits - 1))) & ((1 << bits) - 1);
  endfunction
endpackage

// File: rtl/delta_sw2.sv
module delta_sw2 #(
  parameter int AW  = 3,
  parameter int DW  = 16,
  parameter int BIT = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             in_req,
  input  logic [1:0][AW-1:0]     in_dest,
  input  logic [1:0][DW-1:0]     in_data,
  output logic [1:0]             in_ack,
  output logic [1:0]             out_req,
  output logic [1:0][AW-1:0]     out_dest,
  output logic [1:0][DW-1:0]     out_data,
  input  logic [1:0]             out_ack
);
  logic [1:0] own_v, own_src;
  logic [1:0] nxt_v, nxt_src;
  logic       prio, contested;
  logic [1:0][1:0] want; // want[input][output]

  always_comb begin
    for (int i = 0; i < 2; i++)
      for (int o = 0; o < 2; o++)
        want[i][o] = in_req[i] && (in_dest[i][BIT] == o[0]);
    contested = 1'b0;
    nxt_v     = own_v;
    nxt_src   = own_src;
    for (int o = 0; o < 2; o++) begin
      if (own_v[o]) begin
        nxt_v[o] = in_req[own_src[o]];
      end else if (want[0][o] && want[1][o]) begin
        nxt_v[o]   = 1'b1;
        nxt_src[o] = prio;
        contested  = 1'b1;
      end else if (want[0][o]) begin
        nxt_v[o]   = 1'b1;
        nxt_src[o] = 1'b0;
      end else if (want[1][o]) begin
        nxt_v[o]   = 1'b1;
        nxt_src[o] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v   <= '0;
      own_src <= '0;
      prio    <= 1'b0;
    end else begin
      own_v   <= nxt_v;
      own_src <= nxt_src;
      if (contested) prio <= ~prio;
    end
  end

  always_comb begin
    for (int o = 0; o < 2; o++) begin
      out_req[o]  = own_v[o] && in_req[own_src[o]];
      out_dest[o] = own_v[o] ? in_dest[own_src[o]] : '0;
      out_data[o] = own_v[o] ? in_data[own_src[o]] : '0;
    end
    for (int i = 0; i < 2; i++)
      in_ack[i] = (own_v[0] && (own_src[0] == i[0]) && out_ack[0]) ||
                  (own_v[1] && (own_src[1] == i[0]) && out_ack[1]);
  end
endmodule

// File: rtl/delta_stage.sv
module delta_stage #(
  parameter int N   = 8,
  parameter int AW  = 3,
  parameter int DW  = 16,
  parameter int BIT = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N-1:0]           in_req,
  input  logic [N-1:0][AW-1:0]   in_dest,
  input  logic [N-1:0][DW-1:0]   in_data,
  output logic [N-1:0]           in_ack,
  output logic [N-1:0]           out_req,
  output logic [N-1:0][AW-1:0]   out_dest,
  output logic [N-1:0][DW-1:0]   out_data,
  input  logic [N-1:0]           out_ack
);
  for (genvar k = 0; k < N/2; k++) begin : g_sw
    delta_sw2 #(.AW(AW), .DW(DW), .BIT(BIT)) u_sw (
      .clk      (clk),
      .rst      (rst),
      .in_req   (in_req[2*k+1:2*k]),
      .in_dest  (in_dest[2*k+1:2*k]),
      .in_data  (in_data[2*k+1:2*k]),
      .in_ack   (in_ack[2*k+1:2*k]),
      .out_req  (out_req[2*k+1:2*k]),
      .out_dest (out_dest[2*k+1:2*k]),
      .out_data (out_data[2*k+1:2*k]),
      .out_ack  (out_ack[2*k+1:2*k])
    );
  end
endmodule

// File: rtl/delta_net.sv
module delta_net #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N-1:0]                 req_i,
  input  logic [N-1:0][$clog2(N)-1:0]  dest_i,
  input  logic [N-1:0][DW-1:0]         data_i,
  output logic [N-1:0]                 ack_o,
  input  logic [N-1:0]                 mem_idle_i,
  output logic [N-1:0]                 mem_req_o,
  output logic [N-1:0][DW-1:0]         mem_data_o
);
  localparam int AW = $clog2(N);
  localparam int S  = AW;

  // boundary s: outputs of stage s-1 (boundary 0 = requesters)
  logic [S:0][N-1:0]           b_req, b_ack;
  logic [S:0][N-1:0][AW-1:0]   b_dest;
  logic [S:0][N-1:0][DW-1:0]   b_data;
  // shuffled inputs of stage s
  logic [S-1:0][N-1:0]         s_req, s_ack;
  logic [S-1:0][N-1:0][AW-1:0] s_dest;
  logic [S-1:0][N-1:0][DW-1:0] s_data;

  assign b_req[0]  = req_i;
  assign b_dest[0] = dest_i;
  assign b_data[0] = data_i;

  for (genvar s = 0; s < S; s++) begin : g_stage
    for (genvar j = 0; j < N; j++) begin : g_shuf
      localparam int P = delta_pkg::rotl(j, AW);
      assign s_req[s][P]  = b_req[s][j];
      assign s_dest[s][P] = b_dest[s][j];
      assign s_data[s][P] = b_data[s][j];
      assign b_ack[s][j]  = s_ack[s][P];
    end
    delta_stage #(.N(N), .AW(AW), .DW(DW), .BIT(S-1-s)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_req   (s_req[s]),
      .in_dest  (s_dest[s]),
      .in_data  (s_data[s]),
      .in_ack   (s_ack[s]),
      .out_req  (b_req[s+1]),
      .out_dest (b_dest[s+1]),
      .out_data (b_data[s+1]),
      .out_ack  (b_ack[s+1])
    );
  end

  // last stage: a port acknowledges when it is reached, idle, and addressed
  for (genvar j = 0; j < N; j++) begin : g_end
    assign b_ack[S][j] = b_req[S][j] && mem_idle_i[j] &&
                         (b_dest[S][j] == AW'(j));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o      <= '0;
      mem_req_o  <= '0;
      mem_data_o <= '0;
    end else begin
      ack_o      <= b_ack[0];
      mem_req_o  <= b_req[S];
      mem_data_o <= b_data[S];
    end
  end
endmodule

// File: rtl/delta_net_chk.sv
module delta_net_chk #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic [N-1:0]                 req_i,
  input logic [N-1:0]                 ack_o,
  input logic [N-1:0]                 mem_idle_i,
  input logic [N-1:0]                 mem_req_o
);
  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ack_o == '0 && mem_req_o == '0));

  // R4: each acknowledge owns a distinct memory port
  a_r4_ack_le_ports: assert property (@(posedge clk) disable iff (rst)
    $countones(ack_o) <= $countones(mem_req_o));

  // R6: acknowledges match reached ports that were idle
  a_r6_ack_idle: assert property (@(posedge clk) disable iff (rst)
    $countones(ack_o) == $countones(mem_req_o & $past(mem_idle_i)));

  for (genvar i = 0; i < N; i++) begin : g_rq
    // R2: an acknowledge needs a live request
    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
      ack_o[i] |-> $past(req_i[i]));
    // R8: dropping the request clears the acknowledge at the next edge
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
      $fell(req_i[i]) |=> !ack_o[i]);
  end
endmodule

bind delta_net delta_net_chk #(.N(N), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_i      (req_i),
  .ack_o      (ack_o),
  .mem_idle_i (mem_idle_i),
  .mem_req_o  (mem_req_o)
);

// File: tb/delta_net_tb.sv
`timescale 1ns/1ps
module delta_net_tb;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int DW = 16;

  logic                 clk = 1'b0;
  logic                 rst;
  logic [N-1:0]         req_i;
  logic [N-1:0][AW-1:0] dest_i;
  logic [N-1:0][DW-1:0] data_i;
  logic [N-1:0]         ack_o;
  logic [N-1:0]         mem_idle_i;
  logic [N-1:0]         mem_req_o;
  logic [N-1:0][DW-1:0] mem_data_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  delta_net #(.N(N), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .dest_i(dest_i), .data_i(data_i),
    .ack_o(ack_o), .mem_idle_i(mem_idle_i), .mem_req_o(mem_req_o),
    .mem_data_o(mem_data_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_i = '0; dest_i = '0; data_i = '0; mem_idle_i = '1;
    edges(3);
    check("R1 ack", 64'(ack_o), 64'h0);
    check("R1 mem_req", 64'(mem_req_o), 64'h0);
    check("R1 mem_data", 64'(mem_data_o), 64'h0);
    rst = 1'b0;
    edges(1);
    check("R1 after", 64'(mem_req_o), 64'h0);

    // R2 / R7 / R8: every single pair
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        req_i[s] = 1'b1; dest_i[s] = AW'(d); data_i[s] = DW'(16'h5000 | (s << 4) | d);
        edges(3);
        check("R2 early ack", 64'(ack_o), 64'h0);
        check("R2 early req", 64'(mem_req_o), 64'h0);
        edges(1);
        check("R2 ack", 64'(ack_o), 64'(1 << s));
        check("R2 port", 64'(mem_req_o), 64'(1 << d));
        check("R2 data", 64'(mem_data_o[d]), 64'(16'h5000 | (s << 4) | d));
        data_i[s] = DW'(16'h6000 | (s << 4) | d);
        edges(1);
        check("R7 word2", 64'(mem_data_o[d]), 64'(16'h6000 | (s << 4) | d));
        data_i[s] = DW'(16'h7000 | (s << 4) | d);
        edges(1);
        check("R7 word3", 64'(mem_data_o[d]), 64'(16'h7000 | (s << 4) | d));
        req_i[s] = 1'b0;
        edges(1);
        check("R8 ack drop", 64'(ack_o), 64'h0);
        check("R8 port drop", 64'(mem_req_o), 64'h0);
      end
    end

    // R3: uniform shifts, all requesters together
    for (int k = 0; k < N; k++) begin
      for (int s = 0; s < N; s++) begin
        dest_i[s] = AW'((s + k) % N);
        data_i[s] = DW'(16'hA000 | (s << 4) | k);
      end
      req_i = '1;
      edges(4);
      check("R3 acks", 64'(ack_o), 64'hFF);
      check("R3 ports", 64'(mem_req_o), 64'hFF);
      for (int s = 0; s < N; s++)
        check("R3 data", 64'(mem_data_o[(s + k) % N]), 64'(16'hA000 | (s << 4) | k));
      req_i = '0;
      edges(2);
    end

    // R4 / R5: requesters 0 and 4 collide at stage-0 element 0
    dest_i[0] = 3'd0; data_i[0] = 16'h0C00;
    dest_i[4] = 3'd1; data_i[4] = 16'h4C11;
    req_i[0] = 1'b1; req_i[4] = 1'b1;
    edges(4);
    check("R5 first winner input0", 64'(ack_o), 64'h01);
    check("R4 loser no port", 64'(mem_req_o), 64'h01);
    check("R4 loser no data", 64'(mem_data_o[1]), 64'h0);
    edges(3);
    check("R4 loser still waits", 64'(ack_o), 64'h01);
    req_i[0] = 1'b0;
    edges(4);
    check("R8 regrant not yet", 64'(ack_o[4]), 64'h0);
    edges(1);
    check("R4 retry granted", 64'(ack_o), 64'h10);
    check("R4 retry data", 64'(mem_data_o[1]), 64'h4C11);
    req_i[4] = 1'b0;
    edges(2);
    req_i[0] = 1'b1; req_i[4] = 1'b1;
    edges(4);
    check("R5 second winner input1", 64'(ack_o), 64'h10);
    check("R5 second port", 64'(mem_req_o), 64'h02);
    req_i = '0;
    edges(2);

    // R6: busy port holds the path without acknowledge
    mem_idle_i = '0;
    dest_i[2] = 3'd5; data_i[2] = 16'h2255;
    req_i[2] = 1'b1;
    edges(6);
    check("R6 no ack busy", 64'(ack_o), 64'h0);
    check("R6 path held", 64'(mem_req_o), 64'h20);
    mem_idle_i = 8'h20;
    edges(1);
    check("R6 ack on idle", 64'(ack_o), 64'h04);
    req_i[2] = 1'b0;
    mem_idle_i = '1;
    edges(2);
    check("R8 final clear", 64'(ack_o | mem_req_o), 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule